// File: doc/BRIEF.md
# Instruction RAM Byte-Window Loader

This block lets a host fill a small sequencer program RAM that holds 32-bit instruction words, using only a byte-wide register window. The host first places a starting word address in two address registers. It then sends the bytes of each instruction to one data register. An internal lane pointer tracks which byte of the word comes next. Once all four bytes of a word have arrived, the word is stored and the address moves on to the next word. Reads from the data register return the stored program in the same order and use the same pointer.

A control register carries a load-enable bit and a sequencer-reset bit, both driven out to the sequencer core. Data-register writes only reach the RAM while load enable is set. The RAM is an inferred array of up to 512 words, so the word address is 9 bits wide and wraps around at the top.

Top module: `iram_byte_loader`

## Requirements
- R1: After reset, the control register, both address registers, `load_en` and `seq_rst` all read as zero, and the byte-lane pointer sits at lane 0.
- R2: The register select `bus_sel` decodes as follows: 0 is control, 1 is the data port, 2 is the address low register (word address bits 7:0), and 3 is the address high register. In the address high register only bit 0 holds word-address bit 8. Writes to its bits 7:1 are ignored, and those bits read as 0.
- R3: With load enable set, four data-port writes fill one word, least significant byte first. The whole word is stored at the current address on the fourth write.
- R4: The word address stays unchanged after the first, second and third byte of a word. It increments by one only in the cycle after the fourth byte.
- R5: The word address wraps from 511 to 0 when a word completes at address 511.
- R6: A write to either address register returns the lane pointer to lane 0. Bytes already collected for an unfinished word are then discarded.
- R7: When load enable is clear, data-port writes are ignored. The RAM contents, the word address and the lane pointer all stay unchanged.
- R8: A data-port read returns the byte selected by the lane pointer from the word at the current address. Each read strobe advances the lane and the address in the same way a write does. Reads work whatever the value of load enable.
- R9: If `bus_wr` and `bus_rd` are both high in the same cycle, only the write takes effect, and the read does not advance the pointer.
- R10: Control bit 0 drives `load_en` and control bit 1 drives `seq_rst`. Control bits 7:2 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one per cycle |
| bus_rd | input | 1 | Register read strobe; at select 1 it advances the lane pointer |
| bus_sel | input | 2 | Register select |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Combinational read value of the selected register |
| load_en | output | 1 | Load enable, control bit 0 |
| seq_rst | output | 1 | Sequencer reset, control bit 1 |

## Verification
Whole words are written from several start addresses, including a run of consecutive words. Their readback shows whether the byte order and the commit point are right, and whether any byte landed in the wrong lane. Reading an address register in the middle of a word separates an address that advances on the last byte from one that advances on an earlier byte. The following cases each isolate one piece of pointer or gating logic, because each leaves a different address, lane and RAM content behind:
- a partial word followed by an address write;
- a word completed at address 511;
- writes sent with load enable clear;
- write and read strobes raised together.

// File: rtl/iram_ldr_pkg.sv
package iram_ldr_pkg;

  typedef enum logic [1:0] {
    SEL_CTL     = 2'd0,
    SEL_DATA    = 2'd1,
    SEL_ADDR_LO = 2'd2,
    SEL_ADDR_HI = 2'd3
  } ldr_sel_e;

  // Word address after one completed word, wrapping at 2**aw.
  function automatic logic [15:0] word_addr_next(input logic [15:0] a, input int unsigned aw);
    logic [15:0] mask;
    mask = (16'd1 << aw) - 16'd1;
    return (a + 16'd1) & mask;
  endfunction

  // Pick one byte lane out of a word.
  function automatic logic [7:0] lane_byte(input logic [63:0] w, input int unsigned lane);
    return w[lane*8 +: 8];
  endfunction

endpackage

// File: rtl/ldr_ptr.sv
module ldr_ptr #(
  parameter int ADDR_W     = 9,
  parameter int WORD_BYTES = 4,
  parameter int LANE_W     = $clog2(WORD_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_wr,
  input  logic              hi_wr,
  input  logic [7:0]        wdata,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic [LANE_W-1:0] lane,
  output logic              last_lane
);
  import iram_ldr_pkg::*;

  localparam int HI_W = ADDR_W - 8;
  localparam logic [LANE_W-1:0] LAST = LANE_W'(WORD_BYTES - 1);

  logic [ADDR_W-1:0] addr_inc;

  assign last_lane = (lane == LAST);
  assign addr_inc  = ADDR_W'(word_addr_next(16'(addr), ADDR_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      lane <= '0;
    end else if (lo_wr) begin
      addr[7:0] <= wdata;
      lane      <= '0;
    end else if (hi_wr) begin
      addr[ADDR_W-1:8] <= wdata[HI_W-1:0];
      lane             <= '0;
    end else if (step) begin
      if (last_lane) begin
        addr <= addr_inc;
        lane <= '0;
      end else begin
        lane <= lane + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ldr_assemble.sv
module ldr_assemble #(
  parameter int WORD_BYTES = 4,
  parameter int LANE_W     = $clog2(WORD_BYTES),
  parameter int WORD_W     = 8 * WORD_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [LANE_W-1:0] lane,
  input  logic [7:0]        wdata,
  output logic              commit,
  output logic [WORD_W-1:0] word
);
  localparam logic [LANE_W-1:0] LAST = LANE_W'(WORD_BYTES - 1);

  logic [7:0] stage [WORD_BYTES-1];

  for (genvar g = 0; g < WORD_BYTES - 1; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              stage[g] <= '0;
      else if (take && lane == LANE_W'(g))     stage[g] <= wdata;
    end
    assign word[g*8 +: 8] = stage[g];
  end

  // Top byte bypasses the stage so the word commits in the same cycle.
  assign word[WORD_W-1 -: 8] = wdata;
  assign commit = take && (lane == LAST);

endmodule

// File: rtl/ldr_ram.sv
module ldr_ram #(
  parameter int ADDR_W = 9,
  parameter int WORD_W = 32,
  parameter int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wword,
  output logic [WORD_W-1:0] rword
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wword;
  end

  assign rword = mem[addr];

endmodule

// File: rtl/iram_byte_loader.sv
module iram_byte_loader #(
  parameter int ADDR_W     = 9,
  parameter int WORD_BYTES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_sel,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       load_en,
  output logic       seq_rst
);
  import iram_ldr_pkg::*;

  localparam int LANE_W = $clog2(WORD_BYTES);
  localparam int WORD_W = 8 * WORD_BYTES;
  localparam int HI_W   = ADDR_W - 8;

  logic [1:0]        ctl_q;
  logic [ADDR_W-1:0] addr;
  logic [LANE_W-1:0] lane;
  logic              last_lane;
  logic              lo_wr, hi_wr, ctl_wr, data_wr, data_rd;
  logic              take, step, commit, lane_clr;
  logic [WORD_W-1:0] word_in, word_out;

  assign ctl_wr   = bus_wr && bus_sel == SEL_CTL;
  assign lo_wr    = bus_wr && bus_sel == SEL_ADDR_LO;
  assign hi_wr    = bus_wr && bus_sel == SEL_ADDR_HI;
  assign data_wr  = bus_wr && bus_sel == SEL_DATA;
  assign data_rd  = bus_rd && !bus_wr && bus_sel == SEL_DATA;
  assign take     = data_wr && load_en;
  assign step     = take || data_rd;
  assign lane_clr = lo_wr || hi_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_wr) ctl_q <= bus_wdata[1:0];
  end

  assign load_en = ctl_q[0];
  assign seq_rst = ctl_q[1];

  ldr_ptr #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .LANE_W(LANE_W)) ptr_i (
    .clk(clk), .rst_n(rst_n), .lo_wr(lo_wr), .hi_wr(hi_wr), .wdata(bus_wdata),
    .step(step), .addr(addr), .lane(lane), .last_lane(last_lane)
  );

  ldr_assemble #(.WORD_BYTES(WORD_BYTES), .LANE_W(LANE_W), .WORD_W(WORD_W)) asm_i (
    .clk(clk), .rst_n(rst_n), .take(take), .lane(lane), .wdata(bus_wdata),
    .commit(commit), .word(word_in)
  );

  ldr_ram #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) ram_i (
    .clk(clk), .we(commit), .addr(addr), .wword(word_in), .rword(word_out)
  );

  always_comb begin
    unique case (bus_sel)
      SEL_CTL:     bus_rdata = {6'b0, ctl_q};
      SEL_DATA:    bus_rdata = lane_byte(64'(word_out), 32'(lane));
      SEL_ADDR_LO: bus_rdata = addr[7:0];
      default:     bus_rdata = 8'(addr[ADDR_W-1 -: HI_W]);
    endcase
  end

endmodule

// File: rtl/iram_ldr_chk.sv
module iram_ldr_chk #(
  parameter int ADDR_W     = 9,
  parameter int WORD_BYTES = 4,
  parameter int LANE_W     = $clog2(WORD_BYTES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [1:0]        bus_sel,
  input logic              load_en,
  input logic [ADDR_W-1:0] addr,
  input logic [LANE_W-1:0] lane,
  input logic              step,
  input logic              take,
  input logic              commit,
  input logic              lane_clr
);
  localparam logic [LANE_W-1:0] LAST = LANE_W'(WORD_BYTES - 1);

  a_r4_addr_hold_midword: assert property (@(posedge clk) disable iff (!rst_n)
    (step && lane != LAST) |=> $stable(addr));

  a_r4_addr_inc_last: assert property (@(posedge clk) disable iff (!rst_n)
    (step && lane == LAST) |=> addr == ADDR_W'($past(addr) + 1'b1));

  a_r5_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (step && lane == LAST && (&addr)) |=> addr == '0);

  a_r3_commit_last_lane: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (take && lane == LAST));

  a_r6_lane_clear: assert property (@(posedge clk) disable iff (!rst_n)
    lane_clr |=> lane == '0);

  a_r7_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == 2'd1 && !load_en) |=> ($stable(addr) && $stable(lane)));

  a_r9_write_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_rd && bus_sel == 2'd0) |=> ($stable(addr) && $stable(lane)));

endmodule

bind iram_byte_loader iram_ldr_chk #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .LANE_W(LANE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
  .load_en(load_en), .addr(addr), .lane(lane), .step(step), .take(take),
  .commit(commit), .lane_clr(lane_clr)
);

// File: tb/iram_byte_loader_tb_top.sv
`timescale 1ns/1ps
module iram_byte_loader_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       load_en, seq_rst;

  int vectors = 0;
  int miscompares = 0;

  // Reference state
  logic [8:0]  m_addr = '0;
  int          m_lane = 0;
  logic [1:0]  m_ctl = '0;
  logic [7:0]  m_buf [4];
  logic [31:0] m_mem [512];
  bit          m_valid [512];

  always #4 clk = ~clk;

  iram_byte_loader dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .load_en(load_en), .seq_rst(seq_rst)
  );

  task automatic compare(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic advance();
    if (m_lane == 3) begin
      m_lane = 0;
      m_addr = m_addr + 9'd1;
    end else m_lane++;
  endtask

  // One bus cycle: drive, check combinational outputs, clock, update model.
  task automatic cyc(input string tag, input bit wr, input bit rd, input int sel, input logic [7:0] d);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_sel = 2'(sel); bus_wdata = d;
    #1;
    compare({tag, " load_en"}, {7'b0, load_en}, {7'b0, m_ctl[0]});
    compare({tag, " seq_rst"}, {7'b0, seq_rst}, {7'b0, m_ctl[1]});
    case (sel)
      0: compare(tag, bus_rdata, {6'b0, m_ctl});
      1: if (m_valid[m_addr]) compare(tag, bus_rdata, m_mem[m_addr][m_lane*8 +: 8]);
      2: compare(tag, bus_rdata, m_addr[7:0]);
      default: compare(tag, bus_rdata, {7'b0, m_addr[8]});
    endcase
    @(posedge clk);
    if (wr) begin
      case (sel)
        0: m_ctl = d[1:0];
        1: if (m_ctl[0]) begin
             m_buf[m_lane] = d;
             if (m_lane == 3) begin
               m_mem[m_addr]   = {m_buf[3], m_buf[2], m_buf[1], m_buf[0]};
               m_valid[m_addr] = 1'b1;
             end
             advance();
           end
        2: begin m_addr[7:0] = d; m_lane = 0; end
        default: begin m_addr[8] = d[0]; m_lane = 0; end
      endcase
    end else if (rd && sel == 1) advance();
  endtask

  task automatic set_addr(input string tag, input int a);
    cyc(tag, 1, 0, 2, 8'(a));
    cyc(tag, 1, 0, 3, 8'(a >> 8));
  endtask

  task automatic put_word(input string tag, input logic [31:0] w);
    for (int b = 0; b < 4; b++) cyc(tag, 1, 0, 1, w[b*8 +: 8]);
  endtask

  task automatic get_word(input string tag);
    for (int b = 0; b < 4; b++) cyc(tag, 0, 1, 1, 8'h00);
  endtask

  initial begin
    #(8 * 150000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) m_valid[i] = 1'b0;
    for (int i = 0; i < 4; i++) m_buf[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    cyc("R1 ctl", 0, 0, 0, 8'h00);
    cyc("R1 addr_lo", 0, 0, 2, 8'h00);
    cyc("R1 addr_hi", 0, 0, 3, 8'h00);

    // R10 control bits drive outputs; R2 upper control bits read 0
    cyc("R10 set both", 1, 0, 0, 8'hFF);
    cyc("R10 read", 0, 0, 0, 8'h00);
    cyc("R10 load only", 1, 0, 0, 8'h01);

    // R2 high address register holds one bit
    cyc("R2 hi write", 1, 0, 3, 8'hFE);
    cyc("R2 hi read", 0, 0, 3, 8'h00);
    cyc("R2 hi write1", 1, 0, 3, 8'hFF);
    cyc("R2 hi read1", 0, 0, 3, 8'h00);

    // R3/R4: word at address 5, address checked mid-word
    set_addr("R4 setup", 5);
    cyc("R3 b0", 1, 0, 1, 8'h11);
    cyc("R4 mid1", 0, 0, 2, 8'h00);
    cyc("R3 b1", 1, 0, 1, 8'h22);
    cyc("R3 b2", 1, 0, 1, 8'h33);
    cyc("R4 mid3", 0, 0, 2, 8'h00);
    cyc("R3 b3", 1, 0, 1, 8'h44);
    cyc("R4 after", 0, 0, 2, 8'h00);
    set_addr("R8 setup", 5);
    get_word("R8 read w5");
    cyc("R8 addr after read", 0, 0, 2, 8'h00);

    // R6 partial word discarded by address write
    set_addr("R6 setup", 10);
    cyc("R6 b0", 1, 0, 1, 8'hAA);
    cyc("R6 b1", 1, 0, 1, 8'hBB);
    cyc("R6 relo", 1, 0, 2, 8'd10);
    put_word("R6 full", 32'hD4C3B2A1);
    cyc("R6 addr", 0, 0, 2, 8'h00);
    set_addr("R6 rb", 10);
    get_word("R6 read w10");
    // partial then high-address write
    cyc("R6 b0h", 1, 0, 1, 8'h77);
    cyc("R6 rehi", 1, 0, 3, 8'h00);
    put_word("R6 fullh", 32'h0BADCAFE);
    set_addr("R6 rbh", 11);
    get_word("R6 read w11");

    // R5 wrap at 511
    set_addr("R5 setup", 511);
    put_word("R5 top", 32'hCAFEF00D);
    cyc("R5 lo", 0, 0, 2, 8'h00);
    cyc("R5 hi", 0, 0, 3, 8'h00);
    set_addr("R5 rb", 511);
    get_word("R5 read w511");
    cyc("R5 rd wrap lo", 0, 0, 2, 8'h00);

    // R7 writes ignored with load enable clear; R8 reads still work
    cyc("R7 disable", 1, 0, 0, 8'h00);
    set_addr("R7 setup", 5);
    put_word("R7 ignored", 32'hFFFFFFFF);
    cyc("R7 addr", 0, 0, 2, 8'h00);
    get_word("R8 read disabled w5");
    cyc("R7 addr after rd", 0, 0, 2, 8'h00);
    cyc("R10 enable", 1, 0, 0, 8'h01);

    // R9 write wins over read in the same cycle
    set_addr("R9 setup", 20);
    cyc("R9 ctl+rd", 1, 1, 0, 8'h01);
    cyc("R9 lo", 0, 0, 2, 8'h00);
    cyc("R9 data wr+rd", 1, 1, 1, 8'h5A);
    cyc("R9 data wr+rd", 1, 1, 1, 8'h6B);
    cyc("R9 data wr+rd", 1, 1, 1, 8'h7C);
    cyc("R9 data wr+rd", 1, 1, 1, 8'h8D);
    cyc("R9 lo after", 0, 0, 2, 8'h00);
    set_addr("R9 rb", 20);
    get_word("R9 read w20");

    // R3 run of consecutive words, crossing into the upper half
    set_addr("R3 run", 250);
    for (int w = 0; w < 12; w++) put_word("R3 run", 32'h01020304 * (w + 1) ^ 32'h5A5AA5A5);
    cyc("R4 run hi", 0, 0, 3, 8'h00);
    set_addr("R8 run", 250);
    for (int w = 0; w < 12; w++) get_word("R8 run read");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule